// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for each beat of a four-beat burst into a synchronous memory. A start address is captured when either of two address strobes is asserted: one used by a processor and one by a cache or bus controller. On every following clock where the advance input is high, the two low address bits step to the next beat. The upper address bits stay frozen at the captured value for the whole burst.

A run-time order select picks one of two beat sequences. The linear order counts the low bits upward and wraps inside the aligned four-address block. The interleaved order XORs the starting low bits with a beat number of 0, 1, 2, 3. A flag marks the fourth beat. Advancing past the fourth beat wraps back to the start address, so the counter never stops.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_ni is low, and after it is released with no strobe, addr_o is all zeros and last_o is 0.
- R2: When strobe_proc_i or strobe_ctrl_i is high at a rising clock edge, addr_o equals the addr_i value sampled at that edge from the next cycle on, and last_o is 0. This beat is beat number 0.
- R3: If a strobe and adv_i are high at the same edge, the strobe wins. The beat number goes to 0 and addr_o equals the sampled addr_i.
- R4: The beat number moves forward by one only at an edge where adv_i is high and no strobe is high. With no strobe and adv_i low, addr_o keeps its value.
- R5: When order_lin_i is 1 (linear), addr_o[1:0] equals (start[1:0] + n) mod 4, where n is the beat number.
- R6: When order_lin_i is 0 (interleaved), addr_o[1:0] equals start[1:0] XOR n.
- R7: addr_o bits above bit 1 always equal the captured start address. Only a strobe changes them.
- R8: last_o is 1 exactly when the beat number is 3.
- R9: An advance at beat 3 wraps the beat number to 0, so addr_o[1:0] returns to start[1:0].
- R10: order_lin_i acts combinationally. Changing it mid-burst remaps addr_o in the same cycle and leaves the beat number unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_proc_i | input | 1 | Processor-side address strobe, loads start address |
| strobe_ctrl_i | input | 1 | Controller-side address strobe, loads start address |
| adv_i | input | 1 | Burst advance |
| order_lin_i | input | 1 | 1 = linear order, 0 = interleaved order |
| addr_i | input | ADDR_W | Start address |
| addr_o | output | ADDR_W | Current beat address |
| last_o | output | 1 | High on the fourth beat |

## Verification
The hardest case is a switch of order_lin_i partway through a burst. The remapped address must reflect the beat number that is already held, not a restarted count. The stimulus starts a burst at a start value whose low bits are 1 or 3, since only those starts make the two orders disagree. It advances to beats 1 and 2, toggles the order select between edges, and checks the remapped address before the next edge. The beat-3 wrap is reached the same way, by running five advances from each of the four low-bit start values in both orders.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned BEAT_W = 2;
  localparam int unsigned BEATS  = 1 << BEAT_W;
  typedef logic [BEAT_W-1:0] beat_t;
  typedef enum logic {ORD_XOR = 1'b0, ORD_LIN = 1'b1} order_e;
endpackage

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] start_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     start_o <= '0;
    else if (load_i) start_o <= addr_i;
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  logic  adv_i,
  output beat_t beat_o,
  output logic  last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     beat_o <= '0;
    else if (load_i) beat_o <= '0;           // strobe wins over advance
    else if (adv_i)  beat_o <= beat_o + 1'b1; // wraps modulo BEATS
  end

  assign last_o = (beat_o == beat_t'(BEATS - 1));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
(
  input  beat_t  start_lo_i,
  input  beat_t  beat_i,
  input  order_e order_i,
  output beat_t  lo_o
);
  beat_t lin_lo, xor_lo;

  assign lin_lo = start_lo_i + beat_i;
  assign xor_lo = start_lo_i ^ beat_i;
  assign lo_o   = (order_i == ORD_LIN) ? lin_lo : xor_lo;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_proc_i,
  input  logic              strobe_ctrl_i,
  input  logic              adv_i,
  input  logic              order_lin_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam int unsigned HI_W = ADDR_W - BEAT_W;

  logic              load;
  logic [ADDR_W-1:0] start_q;
  beat_t             beat_q;
  beat_t             lo;
  order_e            order;

  assign load  = strobe_proc_i | strobe_ctrl_i;
  assign order = order_e'(order_lin_i);

  burst_start_reg #(.ADDR_W(ADDR_W)) i_start (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .addr_i (addr_i),
    .start_o(start_q)
  );

  burst_beat_ctr i_beat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .adv_i (adv_i),
    .beat_o(beat_q),
    .last_o(last_o)
  );

  burst_order_map i_map (
    .start_lo_i(start_q[BEAT_W-1:0]),
    .beat_i    (beat_q),
    .order_i   (order),
    .lo_o      (lo)
  );

  generate
    if (HI_W > 0) begin : g_hi
      assign addr_o = {start_q[ADDR_W-1:BEAT_W], lo};
    end else begin : g_lo_only
      assign addr_o = lo;
    end
  endgenerate
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              strobe_proc_i,
  input logic              strobe_ctrl_i,
  input logic              adv_i,
  input logic              order_lin_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              last_o
);
  logic  stb;
  beat_t m_start_lo, m_n;

  assign stb = strobe_proc_i | strobe_ctrl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_start_lo <= '0;
      m_n        <= '0;
    end else if (stb) begin
      m_start_lo <= addr_i[BEAT_W-1:0];
      m_n        <= '0;
    end else if (adv_i) begin
      m_n <= m_n + 1'b1;
    end
  end

  // R2, R3: a strobe loads addr_i regardless of adv_i
  a_r2_strobe_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb |=> (addr_o == $past(addr_i)) && !last_o);

  // R4: no strobe, no advance, stable order -> address held
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stb && !adv_i) |=> ($stable(order_lin_i) -> $stable(addr_o)));

  // R5
  a_r5_linear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    order_lin_i |-> addr_o[BEAT_W-1:0] == beat_t'(m_start_lo + m_n));

  // R6
  a_r6_interleave: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !order_lin_i |-> addr_o[BEAT_W-1:0] == (m_start_lo ^ m_n));

  // R7
  a_r7_upper_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb |=> addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]));

  // R8
  a_r8_last_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o == (m_n == beat_t'(BEATS - 1)));

  // R9
  a_r9_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && adv_i && !stb) |=> addr_o[BEAT_W-1:0] == m_start_lo && !last_o);
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) i_burst_addr_gen_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .strobe_proc_i(strobe_proc_i),
  .strobe_ctrl_i(strobe_ctrl_i),
  .adv_i        (adv_i),
  .order_lin_i  (order_lin_i),
  .addr_i       (addr_i),
  .addr_o       (addr_o),
  .last_o       (last_o)
);

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
  localparam int unsigned ADDR_W = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              strobe_proc_i = 1'b0;
  logic              strobe_ctrl_i = 1'b0;
  logic              adv_i = 1'b0;
  logic              order_lin_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [ADDR_W-1:0] addr_o;
  logic              last_o;

  int n_checks = 0;
  int n_fail   = 0;

  // bench model, built from the requirements
  logic [ADDR_W-1:0] m_start = '0;
  int                m_n = 0;

  always #5 clk_i = ~clk_i;

  burst_addr_gen #(.ADDR_W(ADDR_W)) i_burst_addr_gen (.*);

  function automatic logic [ADDR_W-1:0] exp_addr(input logic lin);
    logic [1:0] lo;
    lo = lin ? 2'(m_start[1:0] + 2'(m_n)) : (m_start[1:0] ^ 2'(m_n));
    return {m_start[ADDR_W-1:2], lo};
  endfunction

  task automatic check(input string req, input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_beat(input string req);
    check(req, addr_o, exp_addr(order_lin_i));
    check({req, " last"}, {{(ADDR_W-1){1'b0}}, last_o}, {{(ADDR_W-1){1'b0}}, (m_n == 3)});
  endtask

  // drive at negedge, one edge, sample 2 ns after it
  task automatic step(input logic sp, input logic sc, input logic adv, input logic [ADDR_W-1:0] a);
    @(negedge clk_i);
    strobe_proc_i = sp; strobe_ctrl_i = sc; adv_i = adv; addr_i = a;
    @(posedge clk_i);
    if (sp || sc) begin m_start = a; m_n = 0; end
    else if (adv) m_n = (m_n + 1) % 4;
    #2;
    strobe_proc_i = 1'b0; strobe_ctrl_i = 1'b0; adv_i = 1'b0;
  endtask

  task automatic t_reset;
    #3;
    check("R1 in reset addr", addr_o, '0);
    check("R1 in reset last", {15'd0, last_o}, '0);
    @(negedge clk_i); rst_ni = 1'b1;
    step(0, 0, 0, 16'hFFFF);
    check("R1 after release addr", addr_o, '0);
    check("R1 after release last", {15'd0, last_o}, '0);
  endtask

  task automatic t_strobes;
    step(1, 0, 0, 16'hA5C2);
    check_beat("R2 proc strobe");
    step(0, 1, 0, 16'h3C71);
    check_beat("R2 ctrl strobe");
    step(1, 1, 0, 16'h0003);
    check_beat("R2 both strobes");
  endtask

  task automatic t_order(input logic lin);
    order_lin_i = lin;
    for (int s = 0; s < 4; s++) begin
      step(s[0], ~s[0], 0, 16'h7E40 | 16'(s));
      for (int b = 0; b < 5; b++) begin
        step(0, 0, 1, 16'h0000);
        check_beat(lin ? "R5 linear beat" : "R6 interleaved beat");
        check("R7 upper held", {addr_o[ADDR_W-1:2], 2'b00}, 16'h7E40);
        if (b == 3) check("R9 wrap to start", addr_o, 16'h7E40 | 16'(s));
      end
    end
  endtask

  task automatic t_hold;
    order_lin_i = 1'b1;
    step(1, 0, 0, 16'h1231);
    step(0, 0, 1, 0);
    for (int k = 0; k < 3; k++) begin
      step(0, 0, 0, 16'hBEEF);
      check_beat("R4 hold without adv");
    end
    check("R4 held value", addr_o, 16'h1232);
  endtask

  task automatic t_priority;
    order_lin_i = 1'b0;
    step(0, 1, 0, 16'h4442);
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    step(1, 0, 1, 16'h9991);
    check("R3 strobe beats adv", addr_o, 16'h9991);
    check_beat("R3 beat reset");
    step(0, 0, 1, 0);
    check("R3 next beat", addr_o, 16'h9990);
  endtask

  task automatic t_last;
    order_lin_i = 1'b1;
    step(1, 0, 0, 16'h0502);
    for (int b = 0; b < 4; b++) begin
      check("R8 last flag", {15'd0, last_o}, {15'd0, b == 3});
      step(0, 0, 1, 0);
    end
    check("R8 last after wrap", {15'd0, last_o}, '0);
  endtask

  task automatic t_mode_switch;
    order_lin_i = 1'b1;
    step(1, 0, 0, 16'h2201);
    step(0, 0, 1, 0);
    check("R10 linear beat1", addr_o, 16'h2202);
    @(negedge clk_i); order_lin_i = 1'b0; #1;
    check("R10 switched to xor", addr_o, 16'h2200);
    step(0, 0, 1, 0);
    check("R10 xor beat2", addr_o, 16'h2203);
    @(negedge clk_i); order_lin_i = 1'b1; #1;
    check("R10 switched back", addr_o, 16'h2203);
    step(0, 0, 1, 0);
    check("R10 linear beat3", addr_o, 16'h2204 - 16'h4 + 16'h0);
    check_beat("R10 count kept");
  endtask

  initial begin : watchdog
    #500000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_strobes();
    t_order(1'b1);
    t_order(1'b0);
    t_hold();
    t_priority();
    t_last();
    t_mode_switch();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule